// File: doc/BRIEF.md
# Nibble-Wide Video Serializer

This block narrows an 8-bit video sample stream onto a 4-bit path. Every accepted byte leaves as two nibbles, most significant first, on the upper half of an 8-bit output port, while the lower half stays at zero. Nibbles advance only on cycles where the nibble-rate enable is high. This enable is generated outside the block and runs at the faster nibble rate.

In mono or raw mode each byte is sent as soon as it arrives, so the nibble rate is twice the byte rate. In colour mode the bytes arrive as 16-bit words split into pairs: luma first, then chroma, with chroma alternating U and V. The block holds the luma byte and sends chroma before luma, so the wire carries U0 Y0 V0 Y1 nibble pairs at four nibbles per 16-bit word. A byte is taken only while the line is active and the nibble shifter is empty. Dropping the line flag clears all pending state, so every line starts on a fresh luma/chroma pair. The line and frame flags are passed out delayed by one register, in step with the data.

Top module: `nibble_serializer`

## Requirements
- R1: After reset, `strobe_o` is low, `port_o` is zero and `ready_o` is low while `line_i` is low.
- R2: `port_o[3:0]` is always zero; nibbles appear on `port_o[7:4]`.
- R3: Each byte is sent as its bits [7:4] first, then its bits [3:0].
- R4: In mono mode (`color_i`=0) each accepted byte yields exactly two nibbles, one per enabled cycle, and no more.
- R5: In colour mode (`color_i`=1) accepted bytes form pairs (first luma, then chroma). The pair is sent as chroma high, chroma low, luma high, luma low, in four consecutive enabled cycles.
- R6: `ready_o` is high only while `line_i` is high and no nibble remains to be sent. A byte is taken on a clock edge with `valid_i` and `ready_o` both high. After a mono byte or a colour chroma byte is taken, `ready_o` is low in the next cycle.
- R7: While `line_i` is low, `port_o` is zero, `strobe_o` is low and `ready_o` is low. A half-received colour pair is discarded, so the next byte taken is luma.
- R8: `line_o` and `frame_o` equal `line_i` and `frame_i` delayed by one clock.
- R9: `strobe_o` is high for exactly the one cycle after a nibble is placed on `port_o`, and only after a cycle with `nib_en_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nib_en_i | input | 1 | Nibble-rate enable |
| color_i | input | 1 | 1 = colour luma/chroma pairs, 0 = mono or raw bytes |
| line_i | input | 1 | Line active flag |
| frame_i | input | 1 | Frame flag |
| valid_i | input | 1 | Input byte valid |
| data_i | input | 8 | Input byte |
| ready_o | output | 1 | Byte accepted this cycle if valid |
| port_o | output | 8 | Nibble on [7:4], zeros on [3:0] |
| strobe_o | output | 1 | New nibble present on `port_o` |
| line_o | output | 1 | Line flag, one cycle delayed |
| frame_o | output | 1 | Frame flag, one cycle delayed |

## Verification
Mono bytes whose two halves differ (A5, 3C, F0, 0F) are sent with the enable high every cycle, and again with it high every other cycle. These patterns separate correct nibble order from swapped halves, and also show whether a nibble can leave without an enable. Colour pairs with distinct luma and chroma values check the chroma-first reordering and the four-nibbles-per-word rate. A lone luma byte followed by a line drop checks that the next line cannot pair stale luma with new data. Handshake timing and the delayed framing flags are checked one cycle at a time.

// File: rtl/nibser_pkg.sv
package nibser_pkg;
  typedef enum logic {
    MODE_MONO  = 1'b0,
    MODE_COLOR = 1'b1
  } mode_e;
endpackage

// File: rtl/nibser_pair.sv
module nibser_pair
  import nibser_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NIB_W  = DATA_W / 2,
  localparam int unsigned WORD_W = 2 * DATA_W,
  localparam int unsigned CNT_W  = $clog2(WORD_W / NIB_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  mode_e             mode_i,
  input  logic              idle_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic              pend_o,
  output logic              load_o,
  output logic [WORD_W-1:0] load_word_o,
  output logic [CNT_W-1:0]  load_nibs_o
);
  localparam logic [CNT_W-1:0] NIBS_BYTE = CNT_W'(DATA_W / NIB_W);
  localparam logic [CNT_W-1:0] NIBS_PAIR = CNT_W'(WORD_W / NIB_W);

  logic              pend_q;
  logic [DATA_W-1:0] luma_q;
  logic              acc;

  assign ready_o = line_i & idle_i;
  assign acc     = valid_i & ready_o;
  assign pend_o  = pend_q;

  always_comb begin
    load_o      = 1'b0;
    load_word_o = '0;
    load_nibs_o = '0;
    if (acc) begin
      if (mode_i == MODE_MONO) begin
        load_o      = 1'b1;
        load_word_o = {data_i, {DATA_W{1'b0}}};
        load_nibs_o = NIBS_BYTE;
      end else if (pend_q) begin
        // chroma goes out ahead of the held luma
        load_o      = 1'b1;
        load_word_o = {data_i, luma_q};
        load_nibs_o = NIBS_PAIR;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      luma_q <= '0;
    end else if (!line_i || mode_i == MODE_MONO) begin
      pend_q <= 1'b0;
    end else if (acc) begin
      if (!pend_q) begin
        luma_q <= data_i;
        pend_q <= 1'b1;
      end else begin
        pend_q <= 1'b0;
      end
    end
  end

  p_pair_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && mode_i == MODE_COLOR) |-> pend_q);
endmodule

// File: rtl/nibser_shift.sv
module nibser_shift #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned CNT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  nibs_i,
  output logic              idle_o,
  output logic [NIB_W-1:0]  nib_o,
  output logic              stb_o
);
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [NIB_W-1:0]  nib_q;
  logic              stb_q;

  assign idle_o = (cnt_q == '0);
  assign nib_o  = nib_q;
  assign stb_o  = stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      nib_q <= '0;
      stb_q <= 1'b0;
    end else if (!line_i) begin
      cnt_q <= '0;
      nib_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (load_i) begin
        sh_q  <= word_i;
        cnt_q <= nibs_i;
      end else if (en_i && cnt_q != '0) begin
        nib_q <= sh_q[WORD_W-1 -: NIB_W];
        sh_q  <= sh_q << NIB_W;
        cnt_q <= cnt_q - 1'b1;
        stb_q <= 1'b1;
      end
    end
  end

  p_strobe_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |-> $past(en_i));
  p_drain_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i && !load_i && en_i && cnt_q == CNT_W'(1)) |=> idle_o);
endmodule

// File: rtl/nibble_serializer.sv
module nibble_serializer
  import nibser_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned NIB_W  = DATA_W / 2,
  localparam int unsigned WORD_W = 2 * DATA_W,
  localparam int unsigned CNT_W  = $clog2(WORD_W / NIB_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nib_en_i,
  input  logic              color_i,
  input  logic              line_i,
  input  logic              frame_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] port_o,
  output logic              strobe_o,
  output logic              line_o,
  output logic              frame_o
);
  mode_e             mode;
  logic              idle_w, pend_w, load_w;
  logic [WORD_W-1:0] word_w;
  logic [CNT_W-1:0]  nibs_w;
  logic [NIB_W-1:0]  nib_w;
  logic              line_q, frame_q;

  assign mode = color_i ? MODE_COLOR : MODE_MONO;

  nibser_pair #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_pair (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_i      (line_i),
    .mode_i      (mode),
    .idle_i      (idle_w),
    .valid_i     (valid_i),
    .data_i      (data_i),
    .ready_o     (ready_o),
    .pend_o      (pend_w),
    .load_o      (load_w),
    .load_word_o (word_w),
    .load_nibs_o (nibs_w)
  );

  nibser_shift #(.WORD_W(WORD_W), .NIB_W(NIB_W), .CNT_W(CNT_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .en_i   (nib_en_i),
    .load_i (load_w),
    .word_i (word_w),
    .nibs_i (nibs_w),
    .idle_o (idle_w),
    .nib_o  (nib_w),
    .stb_o  (strobe_o)
  );

  assign port_o = {nib_w, {(DATA_W - NIB_W){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      line_q  <= line_i;
      frame_q <= frame_i;
    end
  end

  assign line_o  = line_q;
  assign frame_o = frame_q;

  p_idle_port_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_o |-> (port_o == '0));
  p_strobe_line_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> line_o);
  p_accept_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && (!color_i || pend_w)) |=> !ready_o);
endmodule

// File: tb/nibble_serializer_test.sv
module nibble_serializer_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nib_en = 1'b1;
  logic       color = 1'b0;
  logic       line = 1'b0;
  logic       frame = 1'b0;
  logic       valid = 1'b0;
  logic [7:0] data = 8'h00;
  logic       ready_o, strobe_o, line_o, frame_o;
  logic [7:0] port_o;

  bit         en_half = 1'b0;
  logic [3:0] exp_q[$];
  logic [7:0] pend_y;
  int         n_chk = 0;
  int         n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  nibble_serializer uut (
    .clk_i(clk), .rst_ni(rst_n), .nib_en_i(nib_en), .color_i(color),
    .line_i(line), .frame_i(frame), .valid_i(valid), .data_i(data),
    .ready_o(ready_o), .port_o(port_o), .strobe_o(strobe_o),
    .line_o(line_o), .frame_o(frame_o)
  );

  always @(negedge clk) nib_en <= en_half ? ~nib_en : 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && strobe_o) begin
      chk(port_o[3:0] == 4'h0, "R2", port_o[3:0], 0);
      if (exp_q.size() == 0) chk(1'b0, "R4 extra nibble", port_o[7:4], 0);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk(port_o[7:4] == e, "R3/R5 nibble", port_o[7:4], e);
      end
    end
  end

  task automatic send_byte(input logic [7:0] b, input bit chroma);
    if (!color) begin
      exp_q.push_back(b[7:4]); exp_q.push_back(b[3:0]);
    end else if (!chroma) pend_y = b;
    else begin
      exp_q.push_back(b[7:4]); exp_q.push_back(b[3:0]);
      exp_q.push_back(pend_y[7:4]); exp_q.push_back(pend_y[3:0]);
    end
    @(negedge clk);
    data = b; valid = 1'b1;
    while (!ready_o) @(negedge clk);
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic drain(input string req);
    repeat (12) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready_o == 1'b0, "R1 ready", ready_o, 0);
    chk(strobe_o == 1'b0, "R1 strobe", strobe_o, 0);
    chk(port_o == 8'h00, "R1 port", port_o, 0);
    line = 1'b1;
    @(negedge clk);
    chk(ready_o == 1'b1, "R6 ready idle", ready_o, 1);
    chk(line_o == 1'b1, "R8 line", line_o, 1);

    // mono, full rate
    send_byte(8'hA5, 0);
    chk(ready_o == 1'b0, "R6 busy after mono byte", ready_o, 0);
    send_byte(8'h3C, 0);
    send_byte(8'hF0, 0);
    send_byte(8'h0F, 0);
    drain("R4 mono full rate");

    // mono, half rate enable
    en_half = 1'b1;
    send_byte(8'h12, 0);
    send_byte(8'h9E, 0);
    drain("R4 mono half rate");
    en_half = 1'b0;
    repeat (2) @(negedge clk);

    // colour pairs
    color = 1'b1;
    send_byte(8'h11, 0);
    chk(ready_o == 1'b1, "R6 ready after luma", ready_o, 1);
    send_byte(8'hA2, 1);
    chk(ready_o == 1'b0, "R6 busy after chroma", ready_o, 0);
    begin
      int cnt = 0;
      repeat (5) begin
        @(negedge clk);
        if (strobe_o) cnt++;
      end
      chk(cnt == 4, "R5 four nibbles per word", cnt, 4);
    end
    send_byte(8'h33, 0);
    send_byte(8'hB4, 1);
    drain("R5 colour pairs");

    // half pair dropped at line end
    send_byte(8'h55, 0);
    @(negedge clk);
    line = 1'b0;
    @(negedge clk);
    chk(ready_o == 1'b0, "R7 ready low", ready_o, 0);
    repeat (2) begin
      @(negedge clk);
      chk(port_o == 8'h00, "R7 port zero", port_o, 0);
      chk(strobe_o == 1'b0, "R7 strobe low", strobe_o, 0);
    end
    line = 1'b1;
    send_byte(8'h66, 0);
    send_byte(8'hC7, 1);
    drain("R7 fresh pair");

    // framing
    @(negedge clk);
    frame = 1'b1;
    @(negedge clk);
    chk(frame_o == 1'b1, "R8 frame rise", frame_o, 1);
    frame = 1'b0;
    line = 1'b0;
    @(negedge clk);
    chk(frame_o == 1'b0, "R8 frame fall", frame_o, 0);
    chk(line_o == 1'b0, "R8 line fall", line_o, 0);

    finish_run();
  end
endmodule